// File: doc/BRIEF.md
# Multi-Key First-Match Index Tracker

This block is a single-lane search unit. Eight match keys are written into it in one transfer. A scan command then streams data elements through a valid/ready input. For every key the block records the flat position (counted from zero) of the first element that equals that key. Later equal elements leave that slot untouched. An element that equals several keys fills every still-empty slot among them in the same cycle.

A scan runs in one of two modes. In find mode the scan consumes the stream without producing an output stream. Once the last element is taken, the eight positions appear on the index port. In replace mode the scan produces a one-to-one output stream in which every element that filled at least one slot is swapped for an immediate value. The positions stay only in the slot registers. A later drain command reads them out on the index port as eight elements in key order. Index elements are formatted as u16 or u32. An empty slot reads as all ones in either format. In u16 format, a position of 32768 or more also reads as 0xFFFF.

Control is a three-state machine. IDLE accepts key loads and commands. SCAN runs a find or replace pass. EMIT places one index per cycle on the index port. The transitions are:
- IDLE to SCAN on an accepted find or replace command.
- IDLE to EMIT on an accepted drain command.
- SCAN to EMIT on the last element of a find pass.
- SCAN to IDLE on the last element of a replace pass.
- EMIT to IDLE after the eighth index.

A rejected command leaves the machine in IDLE.

Top module: `mki_tracker`

## Requirements
- R1: A key load (key_load_valid high while cmd_ready is high) stores key k from key_load_data[16k+15:16k] and clears all eight slots to the unmatched state.
- R2: During a scan, slot k captures the position of the first accepted element equal to key k. Positions count accepted elements from 0. A later equal element does not change the slot.
- R3: An unmatched slot reads 0xFFFFFFFF in u32 format and 0x0000FFFF in u16 format. In u16 format a matched position of 32768 or more also reads 0x0000FFFF. Otherwise u16 gives the position zero-extended and u32 gives the full position.
- R4: In find mode (cmd_op 0) the eight indices start on the index port in the cycle after the last element is accepted.
- R5: In replace mode (cmd_op 1) each accepted element appears exactly once on the output stream, in order, carrying its last flag. An element that filled a slot is replaced by cmd_imm and all others are unchanged. The output holds its data while out_ready is low.
- R6: Every index emission (find end or drain, cmd_op 2) is exactly eight cycles of idx_valid with idx_sel running 0 to 7 and idx_last on the eighth.
- R7: Format codes are 4'h5 for u16 and 4'h9 for u32. A find or drain command with any other code is rejected, and so is cmd_op 3. A rejection pulses cmd_reject for one cycle after acceptance, produces no index output and changes no slot.
- R8: Slot contents persist after a scan ends, so repeated drains after a find or replace pass return the same positions.
- R9: Accepting a find or replace command clears all eight slots before its first element.
- R10: An element equal to several keys fills all of their empty slots with the same position.
- R11: cmd_ready is high only in IDLE, in_ready is high only during a scan, and a find pass raises out_valid never.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_load_valid | input | 1 | Write all eight keys |
| key_load_data | input | 128 | Eight 16-bit keys, key 0 in the low bits |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 find, 1 replace, 2 drain, 3 reserved |
| cmd_dtype | input | 4 | Index format code |
| cmd_imm | input | 16 | Replacement value for replace mode |
| cmd_ready | output | 1 | Command and key load accepted |
| cmd_reject | output | 1 | Previous command was rejected |
| in_valid | input | 1 | Input element valid |
| in_data | input | 16 | Input element |
| in_last | input | 1 | Final element of the scan |
| in_ready | output | 1 | Input element accepted |
| out_valid | output | 1 | Replace-mode element valid |
| out_data | output | 16 | Replace-mode element |
| out_last | output | 1 | Final element of the replace stream |
| out_ready | input | 1 | Downstream accepts element |
| idx_valid | output | 1 | Index element valid |
| idx_sel | output | 3 | Key number of the index element |
| idx_data | output | 32 | Formatted index |
| idx_last | output | 1 | Eighth index element |

## Verification
The bench builds the block with its default parameters: eight keys, 16-bit elements, a 32-bit position counter and 32-bit index words. The 32-bit counter lets a 33,000-element find pass put matches on both sides of the 32768 boundary, so the u16 cut-off and the full u32 position are both checked on real positions. Keys and data are drawn from a small value range, which makes duplicate keys, repeated matches and multi-key hits frequent across the random passes. The small range also leaves some keys unmatched for the sentinel checks.

// File: rtl/mki_pkg.sv
package mki_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } mki_state_e;

    typedef enum logic [1:0] {
        OP_FIND    = 2'd0,
        OP_REPLACE = 2'd1,
        OP_DRAIN   = 2'd2,
        OP_RSVD    = 2'd3
    } mki_op_e;

    localparam logic [3:0] FMT_U16 = 4'h5;
    localparam logic [3:0] FMT_U32 = 4'h9;

    function automatic logic fmt_legal(input logic [3:0] code);
        return (code == FMT_U16) || (code == FMT_U32);
    endfunction

endpackage

// File: rtl/mki_key_bank.sv
module mki_key_bank #(
    parameter int NUM_KEYS = 8,
    parameter int DATA_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [NUM_KEYS*DATA_W-1:0] load_keys,
    input  logic [DATA_W-1:0]          probe,
    output logic [NUM_KEYS-1:0]        match
);

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic [DATA_W-1:0] key_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_q <= '0;
            end else if (load_en) begin
                key_q <= load_keys[k*DATA_W +: DATA_W];
            end
        end

        assign match[k] = (key_q == probe);
    end

endmodule

// File: rtl/mki_slot_array.sv
module mki_slot_array #(
    parameter int NUM_KEYS = 8,
    parameter int POS_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [NUM_KEYS-1:0]       match,
    input  logic [POS_W-1:0]          pos,
    output logic [NUM_KEYS-1:0]       hit,
    output logic [NUM_KEYS*POS_W-1:0] pos_flat
);

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
        logic             hit_q;
        logic [POS_W-1:0] pos_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit_q <= 1'b0;
                pos_q <= '0;
            end else if (clear) begin
                hit_q <= 1'b0;
                pos_q <= '0;
            end else if (capture && match[k] && !hit_q) begin
                hit_q <= 1'b1;
                pos_q <= pos;
            end
        end

        assign hit[k]                      = hit_q;
        assign pos_flat[k*POS_W +: POS_W]  = pos_q;
    end

endmodule

// File: rtl/mki_formatter.sv
module mki_formatter
    import mki_pkg::*;
#(
    parameter int NUM_KEYS = 8,
    parameter int POS_W    = 32,
    parameter int OUT_W    = 32
) (
    input  logic [$clog2(NUM_KEYS)-1:0] sel,
    input  logic [NUM_KEYS-1:0]         hit,
    input  logic [NUM_KEYS*POS_W-1:0]   pos_flat,
    input  logic [3:0]                  fmt,
    output logic [OUT_W-1:0]            data
);

    localparam int NARROW_W = 16;

    logic             sel_hit;
    logic [POS_W-1:0] sel_pos;
    logic             wide_pos;

    always_comb begin
        sel_hit  = hit[sel];
        sel_pos  = pos_flat[sel*POS_W +: POS_W];
        wide_pos = (sel_pos >> (NARROW_W - 1)) != '0;
        if (fmt == FMT_U16) begin
            if (!sel_hit || wide_pos) begin
                data = OUT_W'({NARROW_W{1'b1}});
            end else begin
                data = OUT_W'(sel_pos[NARROW_W-1:0]);
            end
        end else begin
            if (!sel_hit) begin
                data = '1;
            end else begin
                data = OUT_W'(sel_pos);
            end
        end
    end

endmodule

// File: rtl/mki_ctrl.sv
module mki_ctrl
    import mki_pkg::*;
#(
    parameter int NUM_KEYS = 8,
    parameter int DATA_W   = 16,
    parameter int POS_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        key_load_valid,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [3:0]                  cmd_dtype,
    input  logic [DATA_W-1:0]           cmd_imm,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_last,
    input  logic                        out_ready,
    input  logic                        fresh_hit,
    output logic                        cmd_ready,
    output logic                        cmd_reject,
    output logic                        in_ready,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_data,
    output logic                        out_last,
    output logic                        idx_valid,
    output logic                        idx_last,
    output logic [$clog2(NUM_KEYS)-1:0] idx_sel,
    output logic [3:0]                  fmt_q,
    output logic [POS_W-1:0]            scan_pos,
    output logic                        key_load_en,
    output logic                        slot_clear,
    output logic                        slot_capture
);

    localparam int                  SEL_W    = $clog2(NUM_KEYS);
    localparam logic [SEL_W-1:0]    LAST_SEL = SEL_W'(NUM_KEYS - 1);

    mki_state_e        state_q, state_d;
    mki_op_e           op;
    logic              replace_q;
    logic [DATA_W-1:0] imm_q;
    logic [SEL_W-1:0]  cnt_q;
    logic [POS_W-1:0]  pos_q;
    logic              cmd_fire, cmd_ok, cmd_take, in_fire;

    assign op       = mki_op_e'(cmd_op);
    assign cmd_fire = (state_q == ST_IDLE) && cmd_valid;

    always_comb begin
        case (op)
            OP_FIND:    cmd_ok = fmt_legal(cmd_dtype);
            OP_DRAIN:   cmd_ok = fmt_legal(cmd_dtype);
            OP_REPLACE: cmd_ok = 1'b1;
            default:    cmd_ok = 1'b0;
        endcase
    end

    assign cmd_take = cmd_fire && cmd_ok;
    assign in_fire  = in_valid && in_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_take) begin
                    state_d = (op == OP_DRAIN) ? ST_EMIT : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (in_fire && in_last) begin
                    state_d = replace_q ? ST_IDLE : ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (cnt_q == LAST_SEL) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        cmd_ready    = (state_q == ST_IDLE);
        in_ready     = (state_q == ST_SCAN) && (!replace_q || !out_valid || out_ready);
        idx_valid    = (state_q == ST_EMIT);
        idx_last     = (state_q == ST_EMIT) && (cnt_q == LAST_SEL);
        idx_sel      = cnt_q;
        scan_pos     = pos_q;
        key_load_en  = (state_q == ST_IDLE) && key_load_valid;
        slot_clear   = key_load_en || (cmd_take && (op != OP_DRAIN));
        slot_capture = in_fire;
    end

    // command and position registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            replace_q  <= 1'b0;
            fmt_q      <= FMT_U32;
            imm_q      <= '0;
            cnt_q      <= '0;
            pos_q      <= '0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_reject <= cmd_fire && !cmd_ok;
            if (cmd_take) begin
                replace_q <= (op == OP_REPLACE);
                fmt_q     <= cmd_dtype;
                imm_q     <= cmd_imm;
                cnt_q     <= '0;
                pos_q     <= '0;
            end else begin
                if (in_fire) begin
                    pos_q <= pos_q + 1'b1;
                end
                if (state_q == ST_EMIT) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // replace-mode output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (in_fire && replace_q) begin
            out_valid <= 1'b1;
            out_data  <= fresh_hit ? imm_q : in_data;
            out_last  <= in_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mki_tracker.sv
module mki_tracker
    import mki_pkg::*;
#(
    parameter int NUM_KEYS = 8,
    parameter int DATA_W   = 16,
    parameter int POS_W    = 32,
    parameter int OUT_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        key_load_valid,
    input  logic [NUM_KEYS*DATA_W-1:0]  key_load_data,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [3:0]                  cmd_dtype,
    input  logic [DATA_W-1:0]           cmd_imm,
    output logic                        cmd_ready,
    output logic                        cmd_reject,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_last,
    output logic                        in_ready,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_data,
    output logic                        out_last,
    input  logic                        out_ready,
    output logic                        idx_valid,
    output logic [$clog2(NUM_KEYS)-1:0] idx_sel,
    output logic [OUT_W-1:0]            idx_data,
    output logic                        idx_last
);

    logic [NUM_KEYS-1:0]       match;
    logic [NUM_KEYS-1:0]       hit;
    logic [NUM_KEYS*POS_W-1:0] pos_flat;
    logic [POS_W-1:0]          scan_pos;
    logic [3:0]                fmt_q;
    logic                      key_load_en, slot_clear, slot_capture, fresh_hit;

    assign fresh_hit = |(match & ~hit);

    mki_key_bank #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (key_load_en),
        .load_keys (key_load_data),
        .probe     (in_data),
        .match     (match)
    );

    mki_slot_array #(.NUM_KEYS(NUM_KEYS), .POS_W(POS_W)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (slot_clear),
        .capture  (slot_capture),
        .match    (match),
        .pos      (scan_pos),
        .hit      (hit),
        .pos_flat (pos_flat)
    );

    mki_formatter #(.NUM_KEYS(NUM_KEYS), .POS_W(POS_W), .OUT_W(OUT_W)) u_fmt (
        .sel      (idx_sel),
        .hit      (hit),
        .pos_flat (pos_flat),
        .fmt      (fmt_q),
        .data     (idx_data)
    );

    mki_ctrl #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W), .POS_W(POS_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .key_load_valid (key_load_valid),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_dtype      (cmd_dtype),
        .cmd_imm        (cmd_imm),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_last        (in_last),
        .out_ready      (out_ready),
        .fresh_hit      (fresh_hit),
        .cmd_ready      (cmd_ready),
        .cmd_reject     (cmd_reject),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_last       (out_last),
        .idx_valid      (idx_valid),
        .idx_last       (idx_last),
        .idx_sel        (idx_sel),
        .fmt_q          (fmt_q),
        .scan_pos       (scan_pos),
        .key_load_en    (key_load_en),
        .slot_clear     (slot_clear),
        .slot_capture   (slot_capture)
    );

endmodule

// File: rtl/mki_tracker_chk.sv
module mki_tracker_chk #(
    parameter int NUM_KEYS = 8,
    parameter int DATA_W   = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_ready,
    input logic                        cmd_reject,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [DATA_W-1:0]           out_data,
    input logic                        out_last,
    input logic                        idx_valid,
    input logic                        idx_last,
    input logic [$clog2(NUM_KEYS)-1:0] idx_sel
);

    AST_IDX_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idx_valid) |-> (idx_sel == '0)); // R6

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && !idx_last) |=> (idx_valid && idx_sel == $past(idx_sel) + 1'b1)); // R6

    AST_IDX_END: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && idx_last) |=> !idx_valid); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R5

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (!idx_valid && cmd_ready)); // R7

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && (in_ready || idx_valid))); // R11

endmodule

bind mki_tracker mki_tracker_chk #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .cmd_reject (cmd_reject),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .idx_valid  (idx_valid),
    .idx_last   (idx_last),
    .idx_sel    (idx_sel)
);

// File: tb/tb_mki_tracker.sv
module tb_mki_tracker;

    localparam logic [3:0] U16 = 4'h5;
    localparam logic [3:0] U32 = 4'h9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load_valid = 1'b0;
    logic [127:0] key_load_data = '0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [3:0]   cmd_dtype = U32;
    logic [15:0]  cmd_imm = '0;
    logic         cmd_ready, cmd_reject;
    logic         in_valid = 1'b0;
    logic [15:0]  in_data = '0;
    logic         in_last = 1'b0;
    logic         in_ready;
    logic         out_valid, out_last;
    logic [15:0]  out_data;
    logic         out_ready = 1'b1;
    logic         idx_valid, idx_last;
    logic [2:0]   idx_sel;
    logic [31:0]  idx_data;

    always #4 clk = ~clk;

    mki_tracker dut (.*);

    int total = 0;
    int failed = 0;
    bit finished = 0;
    bit acc_cmd, acc_in;
    int rej_cnt = 0;
    int out_seen = 0;

    logic [31:0] iq[$];
    logic [2:0]  isq[$];
    logic [15:0] oq[$];
    logic        olq[$];
    logic [15:0] eq[$];

    logic [15:0] keys [8];
    bit          mh [8];
    int unsigned mp [8];
    logic [15:0] sd [];

    function automatic logic [31:0] fmt(bit h, int unsigned p, logic [3:0] dt);
        if (dt == U16) return (!h || p >= 32768) ? 32'h0000FFFF : {16'h0, p[15:0]};
        return h ? p : 32'hFFFFFFFF;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        #1;
        acc_cmd = cmd_valid && cmd_ready;
        acc_in  = in_valid && in_ready;
        if (out_valid && out_ready) begin oq.push_back(out_data); olq.push_back(out_last); end
        if (out_valid) out_seen++;
        if (idx_valid) begin iq.push_back(idx_data); isq.push_back(idx_sel); end
        if (cmd_reject) rej_cnt++;
        @(negedge clk);
    endtask

    task automatic load_keys();
        for (int k = 0; k < 8; k++) key_load_data[16*k +: 16] = keys[k];
        key_load_valid = 1'b1;
        tick();
        key_load_valid = 1'b0;
        for (int k = 0; k < 8; k++) mh[k] = 0;
    endtask

    task automatic send_cmd(logic [1:0] op, logic [3:0] dt, logic [15:0] imm);
        cmd_valid = 1'b1; cmd_op = op; cmd_dtype = dt; cmd_imm = imm;
        for (int n = 0; n < 50; n++) begin tick(); if (acc_cmd) break; end
        cmd_valid = 1'b0;
    endtask

    task automatic check_idx(string req, logic [3:0] dt);
        check({req, " count"}, iq.size(), 8);
        for (int k = 0; k < 8 && k < iq.size(); k++) begin
            check({req, " sel"}, isq[k], k);
            check({req, " value"}, iq[k], fmt(mh[k], mp[k], dt));
        end
    endtask

    task automatic drain(string req, logic [3:0] dt);
        iq.delete(); isq.delete();
        send_cmd(2'd2, dt, 16'h0);
        for (int n = 0; n < 10; n++) tick();
        check_idx(req, dt);
    endtask

    // issues the scan command then streams sd[0..len-1]
    task automatic scan(string req, int len, bit rep, logic [3:0] dt, logic [15:0] imm, int bp);
        bit any;
        iq.delete(); isq.delete(); oq.delete(); olq.delete(); eq.delete();
        out_seen = 0;
        send_cmd(rep ? 2'd1 : 2'd0, dt, imm);
        for (int k = 0; k < 8; k++) mh[k] = 0;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_data = sd[i]; in_last = (i == len - 1);
            for (int n = 0; n < 1000; n++) begin
                out_ready = rep ? (($urandom % 100) >= bp) : 1'b1;
                tick();
                if (acc_in) break;
            end
            any = 0;
            for (int k = 0; k < 8; k++)
                if (!mh[k] && sd[i] == keys[k]) begin mh[k] = 1; mp[k] = i; any = 1; end
            eq.push_back(any ? imm : sd[i]);
        end
        in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
        if (!rep) begin
            tick();
            check({req, " R4 first index one cycle after last"}, iq.size(), 1);
            for (int n = 0; n < 10; n++) tick();
            check_idx({req, " R4"}, dt);
            check({req, " R11 no stream in find"}, out_seen, 0);
        end else begin
            for (int n = 0; n < 200 && oq.size() < len; n++) tick();
            check({req, " R5 count"}, oq.size(), len);
            for (int i = 0; i < len && i < oq.size(); i++) begin
                check({req, " R5 data"}, oq[i], eq[i]);
                check({req, " R5 last"}, olq[i], i == len - 1);
            end
            check({req, " R5 no index output"}, iq.size(), 0);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        #1;
        check("R11 reset cmd_ready", cmd_ready, 1);
        check("R11 reset in_ready", in_ready, 0);
        check("R6 reset idx_valid", idx_valid, 0);
        check("R5 reset out_valid", out_valid, 0);
        @(negedge clk);

        for (int k = 0; k < 8; k++) begin mh[k] = 0; mp[k] = 0; keys[k] = 0; end
        drain("R3 drain after reset u32", U32);

        // directed find with duplicate key 7 (R10) and repeated matches (R2)
        keys = '{16'd3, 16'd7, 16'd7, 16'd100, 16'd5, 16'd9, 16'd200, 16'd11};
        load_keys();
        sd = new[12];
        sd = '{16'd5, 16'd3, 16'd7, 16'd3, 16'd9, 16'd7, 16'd11, 16'd5, 16'd1, 16'd7, 16'd2, 16'd11};
        scan("R2 R10 find directed", 12, 0, U32, 16'h0, 0);
        check("R10 duplicate key same position", iq.size() >= 3 ? iq[2] : 32'hDEAD, 32'd2);
        check("R2 first hit kept", iq.size() >= 1 ? iq[0] : 32'hDEAD, 32'd1);
        drain("R8 drain after find u32", U32);
        drain("R8 R3 drain after find u16", U16);

        // rejected commands
        rej_cnt = 0; iq.delete();
        send_cmd(2'd2, 4'h3, 16'h0);
        for (int n = 0; n < 10; n++) tick();
        send_cmd(2'd3, U32, 16'h0);
        for (int n = 0; n < 10; n++) tick();
        send_cmd(2'd0, 4'hA, 16'h0);
        for (int n = 0; n < 10; n++) tick();
        check("R7 reject pulses", rej_cnt, 3);
        check("R7 no index output on reject", iq.size(), 0);
        drain("R7 slots unchanged after reject", U32);

        // directed replace with backpressure
        sd = new[10];
        sd = '{16'd100, 16'd100, 16'd4, 16'd200, 16'd7, 16'd3, 16'd7, 16'd11, 16'd11, 16'd6};
        scan("R5 replace directed", 10, 1, U32, 16'hBEEF, 40);
        drain("R8 drain after replace", U32);

        // new scan with no matches resets slots
        sd = new[6];
        sd = '{16'd1, 16'd2, 16'd4, 16'd6, 16'd8, 16'd10};
        scan("R9 find no match", 6, 0, U16, 16'h0, 0);
        drain("R9 drain sentinel u32", U32);

        // key load clears slots
        sd = new[4];
        sd = '{16'd3, 16'd7, 16'd5, 16'd9};
        scan("R2 find before key load", 4, 0, U32, 16'h0, 0);
        load_keys();
        drain("R1 key load clears slots", U32);

        // random passes
        for (int it = 0; it < 24; it++) begin
            int len;
            bit rep;
            logic [3:0] dt;
            for (int k = 0; k < 8; k++) keys[k] = 16'($urandom % 32);
            load_keys();
            len = 1 + ($urandom % 40);
            sd = new[len];
            for (int i = 0; i < len; i++) sd[i] = 16'($urandom % 40);
            rep = $urandom % 2;
            dt = ($urandom % 2) ? U16 : U32;
            scan(rep ? "R5 random replace" : "R4 random find", len, rep, dt,
                 16'($urandom), 30);
            drain("R8 random drain", ($urandom % 2) ? U16 : U32);
        end

        // u16 boundary on a long find pass
        keys = '{16'd1000, 16'd2000, 16'd3000, 16'd4000, 16'd5000, 16'd5001, 16'd5002, 16'd5003};
        load_keys();
        sd = new[33000];
        for (int i = 0; i < 33000; i++) sd[i] = 16'd0;
        sd[10] = 16'd1000; sd[20000] = 16'd1000; sd[32767] = 16'd2000;
        sd[32768] = 16'd3000; sd[32999] = 16'd4000;
        scan("R3 u16 boundary find", 33000, 0, U16, 16'h0, 0);
        check("R3 u16 last small position", iq.size() >= 2 ? iq[1] : 32'hDEAD, 32'h7FFF);
        check("R3 u16 position 32768 is sentinel", iq.size() >= 3 ? iq[2] : 32'hDEAD, 32'hFFFF);
        drain("R3 u32 full positions", U32);
        check("R2 no overwrite by later match", iq.size() >= 1 ? iq[0] : 32'hDEAD, 32'd10);

        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; failed++;
            $display("FAIL watchdog all requirements actual=running expected=done");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule